// File: doc/BRIEF.md
# Paged Receive Ring Manager

This block places incoming frames into a circular area of packet RAM that is carved into 256-byte pages. The host programs a first page and an end page (exclusive) to bound the ring. Each frame arrives as a byte stream with start and end markers and a good/bad flag at the end. Its bytes go to the RAM write port from offset 4 of the current page onward. When a good frame ends, a 4-byte header goes into offsets 0..3 of the frame's first page, and the current-page pointer moves past the frame.

The host consumes frames by moving a boundary pointer that trails its read position by one page. The receiver never writes into the boundary page. A frame that would need that page is aborted and raises an overwrite warning. Until the host clears the warning, later frames are dropped whole. The receive status and interrupt status registers report the outcome of each frame. An output flag reports that unread frames are waiting in the ring.

Top module: `rx_page_ring`

## Requirements
- R1: After reset, first page = RST_START, end page = RST_STOP, current page = RST_START, boundary = RST_STOP-1, and receive status, interrupt status and ring_nonempty are all 0.
- R2: The bytes of a frame are written through the RAM port in arrival order. The first byte goes to address {current page, 8'h04} and each later byte to the next address.
- R3: When the write address leaves a page whose successor equals the end page, writing continues at offset 0 of the first page.
- R4: After a good end of frame, four header bytes are written to offsets 0,1,2,3 of the frame's first page: status, next page, length low, length high. The length counts every received byte, including the 4 FCS bytes. At least 4 idle cycles must separate an end of frame from the next start.
- R5: After a good frame, the current page becomes the page after the page holding the frame's last byte, wrapped from end page to first page.
- R6: A frame ending with rx_good=0 leaves the current page unchanged. It sets receive status to 8'h02 (bit1 = bad) and does not set interrupt bit0.
- R7: A good frame sets receive status to 8'h01 (bit0 = intact). It writes 8'h01 as the header status byte and sets interrupt status bit0 (frame received).
- R8: A byte that would land in the boundary page is not written. The frame is discarded, the current page is unchanged, interrupt bit1 (overwrite warning) is set and receive status becomes 8'h04 (bit2 = missed).
- R9: While interrupt bit1 is set, every arriving frame is dropped with no RAM write, the current page is unchanged and receive status becomes 8'h04.
- R10: Writing the interrupt status register clears exactly the bits written as 1; bits written as 0 keep their value.
- R11: ring_nonempty is 1 exactly when the page after the boundary (wrapped) differs from the current page.
- R12: Register addresses are 0 first page, 1 end page, 2 boundary, 3 current page, 4 receive status, 5 interrupt status. Pages 0..3 are read/write; reg_rdata shows the register addressed one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Frame byte valid |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_good | input | 1 | Frame status, sampled with rx_eof |
| rx_data | input | 8 | Frame byte |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Registered host read data |
| ram_we | output | 1 | Packet RAM write enable |
| ram_addr | output | PAGE_W+8 | Packet RAM byte address {page, offset} |
| ram_wdata | output | 8 | Packet RAM write data |
| ring_nonempty | output | 1 | Unread frames are present |

## Verification
The hardest case to reach is a frame that fills the free space to the last byte before the boundary page. Next to it is a frame one byte longer, whose final byte alone would hit the boundary. The bench uses a four-page ring and frees each frame at once, so exactly three pages (764 payload bytes) are free at every start. A sweep of lengths around page edges, repeated twice so the start point moves round the ring, reaches both sides of that limit and every wrap position. The overflow case is then followed by a dropped frame and by recovery after the warning is cleared.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  localparam logic [2:0] RA_START = 3'd0;
  localparam logic [2:0] RA_STOP  = 3'd1;
  localparam logic [2:0] RA_BOUND = 3'd2;
  localparam logic [2:0] RA_CURR  = 3'd3;
  localparam logic [2:0] RA_RSR   = 3'd4;
  localparam logic [2:0] RA_ISR   = 3'd5;
  localparam int HDR_BYTES = 4;
  localparam int LEN_W     = 16;
  localparam logic [7:0] HDR_STATUS_OK = 8'h01;
  typedef enum logic [1:0] {S_IDLE, S_RECV, S_DROP, S_HDR} wr_state_e;
endpackage

// File: rtl/rpr_page_step.sv
module rpr_page_step #(
  parameter int PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] pg,
  input  logic [PAGE_W-1:0] first_pg,
  input  logic [PAGE_W-1:0] end_pg,
  output logic [PAGE_W-1:0] nxt
);
  localparam logic [PAGE_W-1:0] ONE = 1;
  logic [PAGE_W-1:0] inc;
  assign inc = pg + ONE;
  assign nxt = (inc == end_pg) ? first_pg : inc;
endmodule

// File: rtl/rpr_regs.sv
module rpr_regs
  import rpr_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int RST_START = 16,
  parameter int RST_STOP  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              ev_commit,
  input  logic [PAGE_W-1:0] ev_next,
  input  logic              ev_bad,
  input  logic              ev_missed,
  input  logic              ev_ovw,
  output logic [PAGE_W-1:0] start_pg,
  output logic [PAGE_W-1:0] stop_pg,
  output logic [PAGE_W-1:0] curr_pg,
  output logic [PAGE_W-1:0] bnd_pg,
  output logic              ovw_hold,
  output logic              ring_nonempty
);
  localparam logic [PAGE_W-1:0] START_INIT = PAGE_W'(RST_START);
  localparam logic [PAGE_W-1:0] BND_INIT   = PAGE_W'(RST_STOP - 1);
  localparam logic [PAGE_W-1:0] STOP_INIT  = PAGE_W'(RST_STOP);

  logic [2:0]        rsr_q;
  logic [1:0]        isr_q, isr_clr, isr_set;
  logic [PAGE_W-1:0] bnd_nxt;

  rpr_page_step #(.PAGE_W(PAGE_W)) u_bstep (
    .pg(bnd_pg), .first_pg(start_pg), .end_pg(stop_pg), .nxt(bnd_nxt)
  );

  assign isr_clr  = (reg_we && reg_addr == RA_ISR) ? reg_wdata[1:0] : 2'b00;
  assign isr_set  = {ev_ovw, ev_commit};
  assign ovw_hold = isr_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      start_pg      <= START_INIT;
      stop_pg       <= STOP_INIT;
      curr_pg       <= START_INIT;
      bnd_pg        <= BND_INIT;
      rsr_q         <= '0;
      isr_q         <= '0;
      ring_nonempty <= 1'b0;
      reg_rdata     <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          RA_START: start_pg <= reg_wdata[PAGE_W-1:0];
          RA_STOP:  stop_pg  <= reg_wdata[PAGE_W-1:0];
          RA_BOUND: bnd_pg   <= reg_wdata[PAGE_W-1:0];
          RA_CURR:  curr_pg  <= reg_wdata[PAGE_W-1:0];
          default: ;
        endcase
      end
      if (ev_commit) curr_pg <= ev_next;
      if (ev_commit)                 rsr_q <= 3'b001;
      else if (ev_bad)               rsr_q <= 3'b010;
      else if (ev_missed || ev_ovw)  rsr_q <= 3'b100;
      isr_q         <= (isr_q & ~isr_clr) | isr_set;
      ring_nonempty <= (bnd_nxt != curr_pg);
      case (reg_addr)
        RA_START: reg_rdata <= 8'(start_pg);
        RA_STOP:  reg_rdata <= 8'(stop_pg);
        RA_BOUND: reg_rdata <= 8'(bnd_pg);
        RA_CURR:  reg_rdata <= 8'(curr_pg);
        RA_RSR:   reg_rdata <= {5'd0, rsr_q};
        RA_ISR:   reg_rdata <= {6'd0, isr_q};
        default:  reg_rdata <= '0;
      endcase
    end
  end

  // R6
  bad_keeps_curr_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_bad && !(reg_we && reg_addr == RA_CURR)) |=> $stable(curr_pg))
    else $error("bad frame moved current page");

  // R8
  ovw_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ev_ovw |=> isr_q[1])
    else $error("overwrite warning not raised");

  // R10
  isr_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == RA_ISR && reg_wdata[1] && !ev_ovw) |=> !isr_q[1])
    else $error("overwrite warning not cleared");
endmodule

// File: rtl/rpr_writer.sv
module rpr_writer
  import rpr_pkg::*;
#(
  parameter int PAGE_W = 8,
  localparam int ADDR_W = PAGE_W + 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_good,
  input  logic [7:0]        rx_data,
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] stop_pg,
  input  logic [PAGE_W-1:0] curr_pg,
  input  logic [PAGE_W-1:0] bnd_pg,
  input  logic              ovw_hold,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              ev_commit,
  output logic [PAGE_W-1:0] ev_next,
  output logic              ev_bad,
  output logic              ev_missed,
  output logic              ev_ovw
);
  wr_state_e         st;
  logic [PAGE_W-1:0] wpage, fpage, pg_c, pg_nxt;
  logic [7:0]        woff, off_c;
  logic [LEN_W-1:0]  count, len_c, len_q;
  logic [1:0]        hidx;
  logic              hit;

  assign pg_c  = (st == S_IDLE) ? curr_pg : wpage;
  assign off_c = (st == S_IDLE) ? 8'(HDR_BYTES) : woff;
  assign len_c = (st == S_IDLE) ? LEN_W'(1) : count + LEN_W'(1);
  assign hit   = (pg_c == bnd_pg);

  rpr_page_step #(.PAGE_W(PAGE_W)) u_wstep (
    .pg(pg_c), .first_pg(start_pg), .end_pg(stop_pg), .nxt(pg_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      wpage     <= '0;
      fpage     <= '0;
      woff      <= '0;
      count     <= '0;
      len_q     <= '0;
      hidx      <= '0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      ev_commit <= 1'b0;
      ev_next   <= '0;
      ev_bad    <= 1'b0;
      ev_missed <= 1'b0;
      ev_ovw    <= 1'b0;
    end else begin
      ram_we    <= 1'b0;
      ev_commit <= 1'b0;
      ev_bad    <= 1'b0;
      ev_missed <= 1'b0;
      ev_ovw    <= 1'b0;
      case (st)
        S_IDLE, S_RECV: begin
          if (rx_valid && (st == S_RECV || rx_sof)) begin
            if (st == S_IDLE && ovw_hold) begin
              ev_missed <= 1'b1;
              if (!rx_eof) st <= S_DROP;
            end else if (hit) begin
              ev_ovw <= 1'b1;
              st     <= rx_eof ? S_IDLE : S_DROP;
            end else begin
              ram_we    <= 1'b1;
              ram_addr  <= {pg_c, off_c};
              ram_wdata <= rx_data;
              count     <= len_c;
              woff      <= off_c + 8'd1;
              wpage     <= (off_c == 8'hFF) ? pg_nxt : pg_c;
              if (st == S_IDLE) fpage <= curr_pg;
              if (rx_eof) begin
                if (rx_good) begin
                  ev_commit <= 1'b1;
                  ev_next   <= pg_nxt;
                  len_q     <= len_c;
                  hidx      <= '0;
                  st        <= S_HDR;
                end else begin
                  ev_bad <= 1'b1;
                  st     <= S_IDLE;
                end
              end else begin
                st <= S_RECV;
              end
            end
          end
        end
        S_DROP: if (rx_valid && rx_eof) st <= S_IDLE;
        S_HDR: begin
          ram_we   <= 1'b1;
          ram_addr <= {fpage, 6'd0, hidx};
          case (hidx)
            2'd0:    ram_wdata <= HDR_STATUS_OK;
            2'd1:    ram_wdata <= 8'(ev_next);
            2'd2:    ram_wdata <= len_q[7:0];
            default: ram_wdata <= len_q[15:8];
          endcase
          hidx <= hidx + 2'd1;
          if (hidx == 2'd3) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  ram_page_in_ring_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_addr[ADDR_W-1:8] >= start_pg && ram_addr[ADDR_W-1:8] < stop_pg))
    else $error("RAM write outside ring");

  // R9
  drop_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && rx_valid && rx_sof && ovw_hold) |=> !ram_we)
    else $error("dropped frame wrote RAM");

  // R4
  hdr_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_HDR) |-> !(rx_valid && rx_sof))
    else $error("frame started during header write");

  // R5
  commit_in_ring_chk: assert property (@(posedge clk) disable iff (rst)
    ev_commit |-> (ev_next >= start_pg && ev_next < stop_pg))
    else $error("next page outside ring");
endmodule

// File: rtl/rx_page_ring.sv
module rx_page_ring #(
  parameter int PAGE_W    = 8,
  parameter int RST_START = 16,
  parameter int RST_STOP  = 32,
  localparam int ADDR_W   = PAGE_W + 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_good,
  input  logic [7:0]        rx_data,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              ring_nonempty
);
  logic [PAGE_W-1:0] start_pg, stop_pg, curr_pg, bnd_pg, ev_next;
  logic              ovw_hold, ev_commit, ev_bad, ev_missed, ev_ovw;

  rpr_regs #(.PAGE_W(PAGE_W), .RST_START(RST_START), .RST_STOP(RST_STOP)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_commit(ev_commit), .ev_next(ev_next), .ev_bad(ev_bad),
    .ev_missed(ev_missed), .ev_ovw(ev_ovw),
    .start_pg(start_pg), .stop_pg(stop_pg), .curr_pg(curr_pg), .bnd_pg(bnd_pg),
    .ovw_hold(ovw_hold), .ring_nonempty(ring_nonempty)
  );

  rpr_writer #(.PAGE_W(PAGE_W)) u_writer (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_good(rx_good), .rx_data(rx_data),
    .start_pg(start_pg), .stop_pg(stop_pg), .curr_pg(curr_pg), .bnd_pg(bnd_pg),
    .ovw_hold(ovw_hold), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ev_commit(ev_commit), .ev_next(ev_next),
    .ev_bad(ev_bad), .ev_missed(ev_missed), .ev_ovw(ev_ovw)
  );
endmodule

// File: tb/tb_rx_page_ring.sv
`timescale 1ns/1ps
module tb_rx_page_ring;
  localparam int FIRST = 2;
  localparam int LAST  = 6;

  logic        clk = 1'b0, rst = 1'b1;
  logic        rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_good = 0;
  logic [7:0]  rx_data = 0;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic        ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic        ring_nonempty;

  logic [7:0] mem [0:2047];
  int total_wr = 0, watch_wr = 0, watch_pg = -1;
  int n_chk = 0, n_fail = 0;
  int c, b;

  always #4 clk = ~clk;

  rx_page_ring dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_good(rx_good), .rx_data(rx_data), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ring_nonempty(ring_nonempty)
  );

  always @(posedge clk) begin
    if (ram_we) begin
      total_wr <= total_wr + 1;
      if (int'(ram_addr[15:8]) == watch_pg) watch_wr <= watch_wr + 1;
      if (ram_addr < 16'd2048) mem[ram_addr[10:0]] <= ram_wdata;
    end
  end

  function automatic int step(input int p);
    return (p + 1 == LAST) ? FIRST : p + 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk) reg_addr = a;
    @(negedge clk) v = int'(reg_rdata);
  endtask

  task automatic wr(input logic [2:0] a, input int v);
    @(negedge clk) begin reg_we = 1; reg_addr = a; reg_wdata = 8'(v); end
    @(negedge clk) reg_we = 0;
  endtask

  task automatic send(input int len, input int seed, input logic good);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_good = good; rx_data = 8'(seed + i * 7);
    end
    @(negedge clk) begin rx_valid = 0; rx_sof = 0; rx_eof = 0; end
    repeat (8) @(negedge clk);
  endtask

  task automatic run_good(input int len, input int seed);
    int p, o, lastp, n, bad, v, wraps;
    send(len, seed, 1'b1);
    p = c; o = 4; bad = 0; wraps = 0; lastp = c;
    for (int i = 0; i < len; i++) begin
      lastp = p;
      if (mem[p * 256 + o] != 8'(seed + i * 7)) bad++;
      o++;
      if (o == 256) begin o = 0; if (p + 1 == LAST) wraps = 1; p = step(p); end
    end
    n = step(lastp);
    chk(wraps ? "R3 wrapped data" : "R2 data", bad, 0);
    chk("R4 header next", int'(mem[c * 256 + 1]), n);
    chk("R4 header length", int'(mem[c * 256 + 2]) + 256 * int'(mem[c * 256 + 3]), len);
    chk("R7 header status", int'(mem[c * 256]), 1);
    rd(3'd3, v); chk("R5 current page", v, n);
    rd(3'd4, v); chk("R7 rx status", v, 1);
    rd(3'd5, v); chk("R7 irq status", v, 1);
    chk("R11 nonempty after frame", int'(ring_nonempty), 1);
    b = (n == FIRST) ? LAST - 1 : n - 1;
    c = n;
    wr(3'd2, b);
    @(negedge clk);
    chk("R11 empty after free", int'(ring_nonempty), 0);
    wr(3'd5, 1);
    rd(3'd5, v); chk("R10 irq cleared", v, 0);
  endtask

  task automatic run_all;
    int v, w0, lens [12];
    lens = '{1, 2, 60, 251, 252, 253, 256, 500, 507, 508, 509, 764};
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    rd(3'd0, v); chk("R1 first page", v, 16);
    rd(3'd1, v); chk("R1 end page", v, 32);
    rd(3'd3, v); chk("R1 current", v, 16);
    rd(3'd2, v); chk("R1 boundary", v, 31);
    rd(3'd4, v); chk("R1 rx status", v, 0);
    rd(3'd5, v); chk("R1 irq status", v, 0);
    chk("R1 nonempty", int'(ring_nonempty), 0);
    wr(3'd0, FIRST); wr(3'd1, LAST); wr(3'd3, FIRST); wr(3'd2, LAST - 1);
    c = FIRST; b = LAST - 1;
    rd(3'd0, v); chk("R12 first page readback", v, FIRST);
    rd(3'd1, v); chk("R12 end page readback", v, LAST);
    @(negedge clk);
    chk("R11 empty after setup", int'(ring_nonempty), 0);
    for (int r = 0; r < 2; r++)
      foreach (lens[k]) run_good(lens[k], 13 * k + 91 * r);
    // bad frame
    send(20, 5, 1'b0);
    rd(3'd3, v); chk("R6 current kept", v, c);
    rd(3'd4, v); chk("R6 rx status bad", v, 2);
    rd(3'd5, v); chk("R6 no irq", v, 0);
    // overflow: one byte more than the free space
    watch_pg = b;
    @(negedge clk);
    w0 = watch_wr;
    send(765, 33, 1'b1);
    chk("R8 boundary page untouched", watch_wr - w0, 0);
    rd(3'd3, v); chk("R8 current kept", v, c);
    rd(3'd5, v); chk("R8 overwrite flag", v, 2);
    rd(3'd4, v); chk("R8 rx status missed", v, 4);
    // dropped while flag held
    w0 = total_wr;
    send(10, 44, 1'b1);
    chk("R9 no writes", total_wr - w0, 0);
    rd(3'd3, v); chk("R9 current kept", v, c);
    rd(3'd4, v); chk("R9 rx status missed", v, 4);
    wr(3'd5, 1);
    rd(3'd5, v); chk("R10 zero bits keep", v, 2);
    wr(3'd5, 2);
    rd(3'd5, v); chk("R10 one bits clear", v, 0);
    run_good(10, 55);
  endtask

  initial begin
    logic timeout = 1'b0;
    fork
      run_all();
      begin repeat (200000) @(posedge clk); timeout = 1'b1; end
    join_any
    disable fork;
    if (timeout) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule